// File: doc/BRIEF.md
# Open-Drain GPIO Port Register Bank

This block holds the port-side state of an eight-bit I/O expander. Each port has a direction bit, an output-level bit and an input-capture bit. Outputs are open-drain: for each pin the block only decides whether to pull it low or leave it released. A pull-up outside the block supplies the high level. A ninth, output-only pin is shared between two roles: an interrupt line driven by an input-change flag, or a plain general-purpose output.

A bus front end, which is outside this block, presents a data byte along with one-cycle strobes. One strobe loads the direction register, one loads the output register and one loads a small control register for the ninth pin. A read strobe captures the pin levels into the input register. Pin levels are sampled through a two-stage synchronizer before they are captured or compared. Any change on an input-configured pin, measured against the value from the last capture, raises the change flag. A read clears it.

Top module: `odgpio_bank`

## Requirements
- R1: During and after synchronous reset, every port is an input (`pin_pull_low` = 0), the input register reads all ones, the output register holds all ones, and the ninth pin is in interrupt mode with no flag set, so `aux_pull_low` = 0.
- R2: Direction bit 1 makes a port an input, and its pull is released. Direction bit 0 makes it an output, and `pin_pull_low[i]` equals the inverse of output register bit i. No pin is ever driven high.
- R3: `dir_wr` loads only the direction register from `wr_data`. `lvl_wr` loads only the output register. Each takes effect on the clock edge that samples the strobe.
- R4: On a clock edge with `rd_stb` high, `in_reg` takes the synchronized level of every pin, including pins that are configured as outputs. `in_reg` holds its value on all other edges.
- R5: A pin change is visible to capture and compare only two clock edges after the edge at which the pin first shows its new level.
- R6: The change flag is set when a synchronized input-configured pin differs from the matching `in_reg` bit. Pins configured as outputs are ignored. Once set, the flag stays set until a read.
- R7: A read strobe clears the change flag, and the clear takes priority over a set in the same cycle.
- R8: With control bit 0 of `wr_data` written as 0 (interrupt mode), `aux_pull_low` is 1 exactly while the change flag is set.
- R9: With control bit 0 written as 1 (output mode), `aux_pull_low` is the inverse of control bit 1 and does not depend on the flag. `ctl_wr` loads both control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | NPORT | Write data byte |
| dir_wr | input | 1 | Load direction register |
| lvl_wr | input | 1 | Load output register |
| ctl_wr | input | 1 | Load ninth-pin control bits (bit0 mode, bit1 level) |
| rd_stb | input | 1 | Capture pins into input register, clear flag |
| pin_in | input | NPORT | Actual pin levels |
| pin_pull_low | output | NPORT | 1 pulls pin low, 0 releases |
| in_reg | output | NPORT | Captured input register |
| aux_pull_low | output | 1 | Ninth pin pull (1 = low) |

## Verification
The hardest situation to reach is a pin change that lands in the same cycle as a read strobe. Here the clear must win, and the captured value decides whether the flag comes back. The synchronizer delay makes this narrow. Directed steps place a read exactly one and two edges after a pin change. A long random phase then toggles pins, directions and strobes independently, so reads collide with changes at every stage of the synchronizer. The bench models the pins as open-drain with a pull-up by feeding the block's own pulls back into `pin_in`. Output-configured pins therefore read back low through the same path a board would use.

// File: rtl/odg_pkg.sv
package odg_pkg;
  localparam int CTL_MODE_BIT = 0;
  localparam int CTL_LVL_BIT  = 1;
  typedef enum logic {AUX_IRQ = 1'b0, AUX_GPO = 1'b1} aux_mode_e;
endpackage

// File: rtl/odg_sync.sv
module odg_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) st[i] <= '1;
        else     st[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) st[i] <= '1;
        else     st[i] <= st[i-1];
      end
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/odg_regs.sv
module odg_regs
  import odg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] wr_data,
  input  logic         dir_wr,
  input  logic         lvl_wr,
  input  logic         ctl_wr,
  output logic [W-1:0] cfg_q,
  output logic [W-1:0] out_q,
  output aux_mode_e    aux_mode,
  output logic         aux_lvl,
  output logic [W-1:0] pull_low
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '1;
      out_q    <= '1;
      aux_mode <= AUX_IRQ;
      aux_lvl  <= 1'b1;
    end else begin
      if (dir_wr) cfg_q <= wr_data;
      if (lvl_wr) out_q <= wr_data;
      if (ctl_wr) begin
        aux_mode <= aux_mode_e'(wr_data[CTL_MODE_BIT]);
        aux_lvl  <= wr_data[CTL_LVL_BIT];
      end
    end
  end

  // open drain: only a pull-low enable per pin
  assign pull_low = ~cfg_q & ~out_q;
endmodule

// File: rtl/odg_chg.sv
module odg_chg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_stb,
  input  logic [W-1:0] sync_q,
  input  logic [W-1:0] cfg_q,
  output logic [W-1:0] in_q,
  output logic         flag
);
  logic diff;
  assign diff = |(cfg_q & (sync_q ^ in_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q <= '1;
      flag <= 1'b0;
    end else begin
      if (rd_stb) in_q <= sync_q;
      flag <= rd_stb ? 1'b0 : (flag | diff);
    end
  end
endmodule

// File: rtl/odgpio_bank.sv
module odgpio_bank
  import odg_pkg::*;
#(
  parameter int NPORT       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPORT-1:0] wr_data,
  input  logic             dir_wr,
  input  logic             lvl_wr,
  input  logic             ctl_wr,
  input  logic             rd_stb,
  input  logic [NPORT-1:0] pin_in,
  output logic [NPORT-1:0] pin_pull_low,
  output logic [NPORT-1:0] in_reg,
  output logic             aux_pull_low
);
  logic [NPORT-1:0] sync_q;
  logic [NPORT-1:0] cfg_q;
  logic [NPORT-1:0] out_q;
  aux_mode_e        aux_mode;
  logic             aux_lvl;
  logic             chg_flag;

  odg_sync #(.W(NPORT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(sync_q)
  );

  odg_regs #(.W(NPORT)) u_regs (
    .clk(clk), .rst(rst), .wr_data(wr_data),
    .dir_wr(dir_wr), .lvl_wr(lvl_wr), .ctl_wr(ctl_wr),
    .cfg_q(cfg_q), .out_q(out_q), .aux_mode(aux_mode),
    .aux_lvl(aux_lvl), .pull_low(pin_pull_low)
  );

  odg_chg #(.W(NPORT)) u_chg (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .sync_q(sync_q),
    .cfg_q(cfg_q), .in_q(in_reg), .flag(chg_flag)
  );

  assign aux_pull_low = (aux_mode == AUX_GPO) ? ~aux_lvl : chg_flag;
endmodule

// File: rtl/odg_checker.sv
module odg_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] wr_data,
  input logic         dir_wr,
  input logic         lvl_wr,
  input logic         ctl_wr,
  input logic         rd_stb,
  input logic [W-1:0] sync_q,
  input logic [W-1:0] cfg_q,
  input logic [W-1:0] in_reg,
  input logic         chg_flag,
  input logic         aux_pull_low
);
  p_dir_load_r3: assert property (@(posedge clk) disable iff (rst)
    dir_wr |=> cfg_q == $past(wr_data));
  p_dir_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (lvl_wr && !dir_wr) |=> cfg_q == $past(cfg_q));
  p_capture_r4: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> in_reg == $past(sync_q));
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(in_reg));
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (chg_flag && !rd_stb) |=> chg_flag);
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> !chg_flag);
  p_gpo_r9: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && wr_data[0] && !rst) |=> aux_pull_low == !$past(wr_data[1]));
endmodule

bind odgpio_bank odg_checker #(.W(NPORT)) u_chk (
  .clk(clk), .rst(rst), .wr_data(wr_data), .dir_wr(dir_wr),
  .lvl_wr(lvl_wr), .ctl_wr(ctl_wr), .rd_stb(rd_stb), .sync_q(sync_q),
  .cfg_q(cfg_q), .in_reg(in_reg), .chg_flag(chg_flag),
  .aux_pull_low(aux_pull_low)
);

// File: tb/odgpio_bank_bench.sv
`timescale 1ns/1ps
module odgpio_bank_bench;
  localparam int N = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] wr_data = '0;
  logic dir_wr = 1'b0, lvl_wr = 1'b0, ctl_wr = 1'b0, rd_stb = 1'b0;
  logic [N-1:0] ext = '1;
  logic [N-1:0] pin_in;
  logic [N-1:0] pin_pull_low, in_reg;
  logic aux_pull_low;
  int checks = 0, fails = 0;
  bit started = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  // open-drain pins with pull-up
  assign pin_in = ext & ~pin_pull_low;

  odgpio_bank u_odgpio_bank (
    .clk(clk), .rst(rst), .wr_data(wr_data), .dir_wr(dir_wr),
    .lvl_wr(lvl_wr), .ctl_wr(ctl_wr), .rd_stb(rd_stb), .pin_in(pin_in),
    .pin_pull_low(pin_pull_low), .in_reg(in_reg), .aux_pull_low(aux_pull_low)
  );

  // behavioural reference: a queue models synchronizer delay
  logic [N-1:0] sq[$];
  logic [N-1:0] m_cfg, m_out, m_in;
  bit m_flag, m_gpo, m_lvl;

  function automatic logic [N-1:0] m_pull();
    return ~m_cfg & ~m_out;
  endfunction
  function automatic bit m_aux();
    return m_gpo ? !m_lvl : m_flag;
  endfunction

  always @(posedge clk) begin
    logic [N-1:0] pin_now, seen;
    pin_now = ext & ~m_pull();
    if (rst) begin
      started = 1'b1;
      sq = '{'1, '1};
      m_cfg = '1; m_out = '1; m_in = '1;
      m_flag = 0; m_gpo = 0; m_lvl = 1;
    end else begin
      seen = sq[0];
      if (rd_stb) m_flag = 0;
      else if ((m_cfg & (seen ^ m_in)) != 0) m_flag = 1;
      if (rd_stb) m_in = seen;
      void'(sq.pop_front());
      sq.push_back(pin_now);
      if (dir_wr) m_cfg = wr_data;
      if (lvl_wr) m_out = wr_data;
      if (ctl_wr) begin m_gpo = wr_data[0]; m_lvl = wr_data[1]; end
    end
  end

  task automatic chk(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      chk("R4 R5 in_reg", in_reg, m_in);
      chk("R2 R3 pin_pull_low", pin_pull_low, m_pull());
      chk("R6 R7 R8 R9 aux_pull_low", {7'b0, aux_pull_low}, {7'b0, m_aux()});
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input int sel, input logic [N-1:0] d);
    wr_data = d;
    dir_wr = (sel == 0); lvl_wr = (sel == 1); ctl_wr = (sel == 2);
    cyc(1);
    dir_wr = 0; lvl_wr = 0; ctl_wr = 0;
  endtask

  task automatic rd();
    rd_stb = 1; cyc(1); rd_stb = 0;
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    cyc(3);
    // R1 reset values
    chk("R1 pull", pin_pull_low, 8'h00);
    chk("R1 in_reg", in_reg, 8'hFF);
    chk("R1 aux", {7'b0, aux_pull_low}, 8'h00);
    rst = 0;
    cyc(2);
    // R5: read one edge after change misses it
    ext[0] = 0; rd_stb = 1; cyc(1); rd_stb = 0;
    chk("R5 early read", in_reg, 8'hFF);
    chk("R8 no flag yet", {7'b0, aux_pull_low}, 8'h00);
    cyc(1);
    chk("R5 flag after two edges", {7'b0, aux_pull_low}, 8'h00);
    cyc(1);
    chk("R6 R8 flag set", {7'b0, aux_pull_low}, 8'h01);
    rd();
    chk("R4 capture", in_reg, 8'hFE);
    chk("R7 cleared", {7'b0, aux_pull_low}, 8'h00);
    // R2 R3: output on bit 5 pulls low
    wr(0, 8'hDF);
    chk("R3 dir only", pin_pull_low, 8'h00);
    wr(1, 8'hDF);
    chk("R2 pull bit5", pin_pull_low, 8'h20);
    cyc(4);
    chk("R6 output pin ignored", {7'b0, aux_pull_low}, 8'h00);
    rd();
    chk("R4 loopback read", in_reg, 8'hDE);
    // R9 output mode
    wr(2, 8'h01);
    chk("R9 gpo low", {7'b0, aux_pull_low}, 8'h01);
    ext[3] = 0; cyc(4);
    wr(2, 8'h03);
    chk("R9 gpo ignores flag", {7'b0, aux_pull_low}, 8'h00);
    wr(2, 8'h00);
    chk("R8 flag shows in irq mode", {7'b0, aux_pull_low}, 8'h01);
    // R7: read same cycle as a set-causing change
    rd();
    ext[3] = 1; cyc(2);
    rd_stb = 1; cyc(1); rd_stb = 0;
    chk("R7 read wins", {7'b0, aux_pull_low}, 8'h00);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      ext = 8'($urandom);
      wr_data = 8'($urandom);
      dir_wr = ($urandom % 5) == 0;
      lvl_wr = ($urandom % 5) == 0;
      ctl_wr = ($urandom % 9) == 0;
      rd_stb = ($urandom % 4) == 0;
      cyc(1);
    end
    dir_wr = 0; lvl_wr = 0; ctl_wr = 0; rd_stb = 0;
    cyc(2);
    summary();
  end
endmodule